// File: doc/BRIEF.md
# Fixed Time-Slot Memory Bus Scheduler

This block shares one memory bus among eight requesters by means of a repeating frame of eight slots. Each slot lasts one clock cycle and belongs to one requester for good. No arbitration takes place. In its own slot, a requester may start one access to one of twelve memory banks. The banks are not interleaved: the upper address bits name the bank and the lower bits give the word within it. After a bank is accessed it stays occupied for a whole frame. An owner that targets an occupied bank loses its slot and sees a retry pulse. A bank number beyond the last bank is refused with its own pulse.

Read data comes back a fixed `RD_LAT` cycles after the access was accepted. It is tagged with the 3-bit slot number of the requester that issued it. The memory arrays sit outside the block on a plain port. The memory must hand back read data one cycle after `mem_en`. The block stores that data and holds it for the remaining return stages.

Each requester has a valid/ready request channel. A request is taken in the cycle where both `req_valid[i]` and `req_ready[i]` are high. `req_ready[i]` can only be high during slot i, and only when the addressed bank exists and is free. A requester that keeps valid high while ready is low waits for a later frame; nothing is queued for it. The response side has no back-pressure, because the return time is fixed. Consumers must take `rsp_valid` in the cycle it appears. `RD_LAT` must be at least 2.

Top module: `slot_bus_sched`

## Requirements
- R1: After reset `slot_id` is 0. It then advances by one each clock and wraps from 7 to 0.
- R2: Requester i is owned by slot i. The order is: 0 processor-1 data, 1 processor-2 data, 2 I/O processor, 3 processor-1 fetch, 4 processor-2 fetch, 5 to 7 DMA channels 1 to 3. `req_ready[i]` is low in every other slot, and a request raised outside its slot causes no memory activity.
- R3: Address bits [15:12] select the bank and bits [11:0] the word. A bank number of 12 or more pulses `req_bad[i]` in the owner's slot and causes no memory activity.
- R4: An accepted access keeps its bank refusing for the next 7 cycles. The bank accepts again exactly 8 cycles after the access. Reset frees all banks.
- R5: If the owner is valid and its bank is occupied, `req_retry[i]` is high in that slot, `mem_en` stays low, and no other requester gets the slot.
- R6: An accepted read raises `rsp_valid` exactly `RD_LAT` cycles later. It carries the data stored at that address and `rsp_tag` equal to the issuing slot.
- R7: An accepted write updates memory and produces no response.
- R8: A slot whose owner is not valid produces no bank activity.
- R9: On acceptance, `mem_en` is high in the same cycle. `mem_bank`, `mem_offset`, `mem_we` and `mem_wdata` carry the owner's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 8 | Request valid, one bit per requester |
| req_ready | output | 8 | Request accepted this cycle if valid |
| req_write | input | 8 | 1 = write, 0 = read, per requester |
| req_addr | input | 8*16 | Packed addresses, requester i at [16i +: 16] |
| req_wdata | input | 8*16 | Packed write data, requester i at [16i +: 16] |
| req_retry | output | 8 | Slot lost because the bank was occupied |
| req_bad | output | 8 | Slot lost because the bank number is out of range |
| slot_id | output | 3 | Current slot number |
| mem_en | output | 1 | Bank access strobe |
| mem_we | output | 1 | Access is a write |
| mem_bank | output | 4 | Target bank |
| mem_offset | output | 12 | Word within the bank |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after mem_en |
| rsp_valid | output | 1 | Read response present |
| rsp_tag | output | 3 | Slot number of the issuing requester |
| rsp_data | output | 16 | Read data |

## Verification
A vector table sends requests spread over four frames. It puts a second access to the same bank at distances of 3, 5, 7, 8 and 9 cycles, which separates a hold of exactly one frame from one cycle too short or too long. Writes followed by reads from other requesters show that data, tag and return time line up. Back-to-back reads in slots 6 and 7 show that the return stages do not mix up neighbours. Out-of-range banks and requests raised in a foreign slot show that refused requests leave the bus idle. A reset in the middle of a run, one cycle after an access, shows that reset frees a bank.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int NUM_SLOTS = 8;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  typedef logic [SLOT_W-1:0] slot_t;

  // Requester functions; the numeric value is the requester index.
  typedef enum logic [SLOT_W-1:0] {
    FN_P1_DATA  = 3'd0,
    FN_P2_DATA  = 3'd1,
    FN_IOP      = 3'd2,
    FN_P1_FETCH = 3'd3,
    FN_P2_FETCH = 3'd4,
    FN_DMA1     = 3'd5,
    FN_DMA2     = 3'd6,
    FN_DMA3     = 3'd7
  } fn_e;

  // Hard-wired slot-to-function table: the slot order is behaviour.
  function automatic fn_e owner_of(slot_t s);
    case (s)
      3'd0:    return FN_P1_DATA;
      3'd1:    return FN_P2_DATA;
      3'd2:    return FN_IOP;
      3'd3:    return FN_P1_FETCH;
      3'd4:    return FN_P2_FETCH;
      3'd5:    return FN_DMA1;
      3'd6:    return FN_DMA2;
      default: return FN_DMA3;
    endcase
  endfunction
endpackage

// File: rtl/sbs_slot_ctr.sv
module sbs_slot_ctr
  import sbs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output slot_t slot
);
  always_ff @(posedge clk) begin
    if (!rst_n) slot <= '0;
    else        slot <= slot + slot_t'(1);
  end
endmodule

// File: rtl/sbs_bank_busy.sv
module sbs_bank_busy #(
  parameter int NUM_BANKS = 12,
  parameter int BANK_W    = 4,
  parameter int HOLD      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue,
  input  logic [BANK_W-1:0]    issue_bank,
  output logic [NUM_BANKS-1:0] busy
);
  localparam int CNT_W = $clog2(HOLD);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  cnt <= '0;
      else if (issue && issue_bank == BANK_W'(b))  cnt <= CNT_W'(HOLD - 1);
      else if (cnt != '0)                          cnt <= cnt - CNT_W'(1);
    end
    assign busy[b] = (cnt != '0);
  end
endmodule

// File: rtl/sbs_rtn_pipe.sv
module sbs_rtn_pipe
  import sbs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LAT    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  slot_t             load_tag,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output slot_t             rsp_tag,
  output logic [DATA_W-1:0] rsp_data
);
  logic  vld_q [LAT];
  slot_t tag_q [LAT];
  logic [DATA_W-1:0] dat_q [1:LAT-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < LAT; k++) vld_q[k] <= 1'b0;
    end else begin
      vld_q[0] <= load;
      for (int k = 1; k < LAT; k++) vld_q[k] <= vld_q[k-1];
    end
  end

  always_ff @(posedge clk) begin
    tag_q[0] <= load_tag;
    for (int k = 1; k < LAT; k++) tag_q[k] <= tag_q[k-1];
  end

  // Memory answers one cycle after issue; stage 1 captures it.
  for (genvar k = 1; k < LAT; k++) begin : g_dat
    if (k == 1) begin : g_first
      always_ff @(posedge clk) dat_q[k] <= mem_rdata;
    end else begin : g_next
      always_ff @(posedge clk) dat_q[k] <= dat_q[k-1];
    end
  end

  assign rsp_valid = vld_q[LAT-1];
  assign rsp_tag   = tag_q[LAT-1];
  assign rsp_data  = dat_q[LAT-1];
endmodule

// File: rtl/slot_bus_sched.sv
module slot_bus_sched
  import sbs_pkg::*;
#(
  parameter  int NUM_BANKS = 12,
  parameter  int OFF_W     = 12,
  parameter  int DATA_W    = 16,
  parameter  int RD_LAT    = 5,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int ADDR_W    = BANK_W + OFF_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SLOTS-1:0]        req_valid,
  output logic [NUM_SLOTS-1:0]        req_ready,
  input  logic [NUM_SLOTS-1:0]        req_write,
  input  logic [NUM_SLOTS*ADDR_W-1:0] req_addr,
  input  logic [NUM_SLOTS*DATA_W-1:0] req_wdata,
  output logic [NUM_SLOTS-1:0]        req_retry,
  output logic [NUM_SLOTS-1:0]        req_bad,
  output logic [SLOT_W-1:0]           slot_id,
  output logic                        mem_en,
  output logic                        mem_we,
  output logic [BANK_W-1:0]           mem_bank,
  output logic [OFF_W-1:0]            mem_offset,
  output logic [DATA_W-1:0]           mem_wdata,
  input  logic [DATA_W-1:0]           mem_rdata,
  output logic                        rsp_valid,
  output logic [SLOT_W-1:0]           rsp_tag,
  output logic [DATA_W-1:0]           rsp_data
);
  slot_t slot_q;
  slot_t own_idx;
  logic [ADDR_W-1:0] addr_a  [NUM_SLOTS];
  logic [DATA_W-1:0] wdata_a [NUM_SLOTS];
  logic [ADDR_W-1:0] sel_addr;
  logic [BANK_W-1:0] sel_bank;
  logic              sel_valid, in_range, busy_sel, gate_ok, issue;
  logic [NUM_BANKS-1:0] busy;

  sbs_slot_ctr u_slot (.clk(clk), .rst_n(rst_n), .slot(slot_q));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_unpack
    assign addr_a[i]  = req_addr[i*ADDR_W +: ADDR_W];
    assign wdata_a[i] = req_wdata[i*DATA_W +: DATA_W];
  end

  assign own_idx   = slot_t'(owner_of(slot_q));
  assign sel_valid = req_valid[own_idx];
  assign sel_addr  = addr_a[own_idx];
  assign sel_bank  = sel_addr[ADDR_W-1:OFF_W];
  assign in_range  = {1'b0, sel_bank} < (BANK_W+1)'(NUM_BANKS);

  always_comb begin
    busy_sel = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (sel_bank == BANK_W'(b)) busy_sel = busy[b];
  end

  assign gate_ok = in_range & ~busy_sel;
  assign issue   = sel_valid & gate_ok;

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      req_ready[i] = (own_idx == slot_t'(i)) & gate_ok;
      req_retry[i] = (own_idx == slot_t'(i)) & sel_valid & in_range & busy_sel;
      req_bad[i]   = (own_idx == slot_t'(i)) & sel_valid & ~in_range;
    end
  end

  sbs_bank_busy #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .HOLD(NUM_SLOTS)) u_busy (
    .clk(clk), .rst_n(rst_n), .issue(issue), .issue_bank(sel_bank), .busy(busy)
  );

  assign mem_en     = issue;
  assign mem_we     = req_write[own_idx];
  assign mem_bank   = sel_bank;
  assign mem_offset = sel_addr[OFF_W-1:0];
  assign mem_wdata  = wdata_a[own_idx];
  assign slot_id    = slot_q;

  sbs_rtn_pipe #(.DATA_W(DATA_W), .LAT(RD_LAT)) u_rtn (
    .clk(clk), .rst_n(rst_n),
    .load(issue & ~req_write[own_idx]), .load_tag(slot_q),
    .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/sbs_chk.sv
module sbs_chk
  import sbs_pkg::*;
#(
  parameter  int NUM_BANKS = 12,
  parameter  int RD_LAT    = 5,
  localparam int BANK_W    = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_SLOTS-1:0] req_valid,
  input logic [NUM_SLOTS-1:0] req_ready,
  input logic [NUM_SLOTS-1:0] req_retry,
  input logic [NUM_SLOTS-1:0] req_bad,
  input logic [SLOT_W-1:0]    slot_id,
  input logic                 mem_en,
  input logic                 mem_we,
  input logic [BANK_W-1:0]    mem_bank,
  input logic                 rsp_valid,
  input logic [SLOT_W-1:0]    rsp_tag
);
  logic              past_ok;
  logic              bh_v [NUM_SLOTS-1];
  logic [BANK_W-1:0] bh_b [NUM_SLOTS-1];
  logic              hv   [RD_LAT];
  slot_t             ht   [RD_LAT];
  logic              clash;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      for (int k = 0; k < NUM_SLOTS-1; k++) bh_v[k] <= 1'b0;
      for (int k = 0; k < RD_LAT; k++)      hv[k]   <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      bh_v[0] <= mem_en;
      for (int k = 1; k < NUM_SLOTS-1; k++) bh_v[k] <= bh_v[k-1];
      hv[0] <= mem_en && !mem_we;
      for (int k = 1; k < RD_LAT; k++) hv[k] <= hv[k-1];
    end
  end

  always_ff @(posedge clk) begin
    bh_b[0] <= mem_bank;
    for (int k = 1; k < NUM_SLOTS-1; k++) bh_b[k] <= bh_b[k-1];
    ht[0] <= slot_id;
    for (int k = 1; k < RD_LAT; k++) ht[k] <= ht[k-1];
  end

  always_comb begin
    clash = 1'b0;
    for (int k = 0; k < NUM_SLOTS-1; k++)
      if (bh_v[k] && bh_b[k] == mem_bank) clash = 1'b1;
  end

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> slot_id == slot_t'($past(slot_id) + 1'b1)); // R1
  AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready)); // R2
  AST_READY_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready != '0) |-> req_ready[slot_t'(owner_of(slot_id))]); // R2
  AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> ({1'b0, mem_bank} < (BANK_W+1)'(NUM_BANKS))); // R3
  AST_BANK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !clash); // R4
  AST_LOST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_retry | req_bad) != '0) |-> !mem_en); // R5
  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    hv[RD_LAT-1] |-> (rsp_valid && rsp_tag == ht[RD_LAT-1])); // R6
  AST_RSP_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> hv[RD_LAT-1]); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) |-> !mem_en); // R8
  AST_ISSUE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> ((req_valid & req_ready) != '0)); // R9
endmodule

bind slot_bus_sched sbs_chk #(.NUM_BANKS(NUM_BANKS), .RD_LAT(RD_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_retry(req_retry), .req_bad(req_bad), .slot_id(slot_id),
  .mem_en(mem_en), .mem_we(mem_we), .mem_bank(mem_bank),
  .rsp_valid(rsp_valid), .rsp_tag(rsp_tag)
);

// File: tb/slot_bus_sched_tb_top.sv
module slot_bus_sched_tb_top;
  localparam int NS = 8, AW = 16, DW = 16, LAT = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] req_valid = '0, req_write = '0;
  logic [NS-1:0] req_ready, req_retry, req_bad;
  logic [NS*AW-1:0] req_addr = '0;
  logic [NS*DW-1:0] req_wdata = '0;
  logic [2:0] slot_id, rsp_tag;
  logic mem_en, mem_we, rsp_valid;
  logic [3:0] mem_bank;
  logic [11:0] mem_offset;
  logic [DW-1:0] mem_wdata, mem_rdata, rsp_data;

  int checks = 0, errors = 0, cyc = 0;
  int due_q[$];
  int tag_q[$];
  int dat_q[$];

  always #10 clk = ~clk;

  slot_bus_sched dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_retry(req_retry), .req_bad(req_bad), .slot_id(slot_id),
    .mem_en(mem_en), .mem_we(mem_we), .mem_bank(mem_bank), .mem_offset(mem_offset),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
  );

  // Memory model: registered read, one cycle after mem_en.
  logic [DW-1:0] mem [16][16];
  initial begin
    for (int b = 0; b < 16; b++) for (int w = 0; w < 16; w++) mem[b][w] = '0;
    mem_rdata = '0;
  end
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_en) begin
      mem_rdata <= mem[mem_bank][mem_offset[3:0]];
      if (mem_we) mem[mem_bank][mem_offset[3:0]] <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Response monitor: expected responses are due at fixed cycles.
  always @(negedge clk) begin
    if (rst_n && due_q.size() != 0 && due_q[0] == cyc) begin
      chk(rsp_valid == 1'b1, "R6 rsp_valid", int'(rsp_valid), 1);
      chk(int'(rsp_tag) == tag_q[0], "R6 rsp_tag", int'(rsp_tag), tag_q[0]);
      chk(int'(rsp_data) == dat_q[0], "R6 rsp_data", int'(rsp_data), dat_q[0]);
      void'(due_q.pop_front()); void'(tag_q.pop_front()); void'(dat_q.pop_front());
    end else if (rst_n && rsp_valid) begin
      chk(1'b0, "R7 unexpected response", int'(rsp_tag), -1);
    end
  end

  // {req[2:0], write, bank[3:0], off[3:0], data[15:0], outcome[1:0]}
  // outcome: 0 accepted, 1 retry, 2 bad bank. data = expected read value.
  localparam logic [29:0] VEC [14] = '{
    {3'd0, 1'b1, 4'd3,  4'd1, 16'hA101, 2'd0},
    {3'd3, 1'b0, 4'd3,  4'd1, 16'h0000, 2'd1},
    {3'd5, 1'b1, 4'd4,  4'd2, 16'hB202, 2'd0},
    {3'd0, 1'b0, 4'd3,  4'd1, 16'hA101, 2'd0},
    {3'd1, 1'b1, 4'd11, 4'd5, 16'hC303, 2'd0},
    {3'd2, 1'b0, 4'd4,  4'd2, 16'h0000, 2'd1},
    {3'd4, 1'b0, 4'd4,  4'd2, 16'h0000, 2'd1},
    {3'd5, 1'b0, 4'd4,  4'd2, 16'hB202, 2'd0},
    {3'd6, 1'b1, 4'd12, 4'd0, 16'h1111, 2'd2},
    {3'd7, 1'b1, 4'd0,  4'd7, 16'hD404, 2'd0},
    {3'd1, 1'b0, 4'd11, 4'd5, 16'hC303, 2'd0},
    {3'd6, 1'b0, 4'd4,  4'd2, 16'hB202, 2'd0},
    {3'd7, 1'b0, 4'd0,  4'd7, 16'hD404, 2'd0},
    {3'd2, 1'b0, 4'd15, 4'd0, 16'h0000, 2'd2}
  };

  task automatic drive(input int r, input bit wr, input int bank, input int off, input int data);
    req_valid[r] = 1'b1;
    req_write[r] = wr;
    req_addr[r*AW +: AW] = AW'((bank << 12) | off);
    req_wdata[r*DW +: DW] = DW'(data);
  endtask

  task automatic run_vec(input int r, input bit wr, input int bank, input int off,
                         input int data, input int outcome);
    @(negedge clk);
    while (int'(slot_id) != r) @(negedge clk);
    drive(r, wr, bank, off, data);
    #1;
    if (outcome == 0) begin
      chk(req_ready[r] && mem_en && !req_retry[r], "R2 accept in own slot", int'(req_ready), 1 << r);
      chk(mem_bank == 4'(bank) && mem_offset == 12'(off) && mem_we == wr,
          "R9 memory port", int'({mem_we, mem_bank, mem_offset}), (int'(wr) << 16) | (bank << 12) | off);
      if (!wr) begin due_q.push_back(cyc + LAT); tag_q.push_back(r); dat_q.push_back(data); end
    end else if (outcome == 1) begin
      chk(req_retry[r] && !req_ready[r] && !mem_en, "R4/R5 busy bank retry", int'(req_retry), 1 << r);
    end else begin
      chk(req_bad[r] && !mem_en && !req_retry[r], "R3 bad bank", int'(req_bad), 1 << r);
    end
    @(posedge clk); #1;
    req_valid[r] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_en == 1'b0 && rsp_valid == 1'b0, "R1 reset quiet", int'({mem_en, rsp_valid}), 0);
    rst_n = 1'b1;
    #1;
    chk(slot_id == 3'd0, "R1 slot after reset", int'(slot_id), 0);
    for (int k = 1; k < 10; k++) begin
      @(negedge clk);
      chk(int'(slot_id) == k % 8, "R1 slot sequence", int'(slot_id), k % 8);
    end

    // Vector table
    for (int v = 0; v < 14; v++) begin
      run_vec(int'(VEC[v][29:27]), VEC[v][26], int'(VEC[v][25:22]), int'(VEC[v][21:18]),
              int'(VEC[v][17:2]), int'(VEC[v][1:0]));
    end

    // R8: idle frame
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(mem_en == 1'b0, "R8 idle slot", int'(mem_en), 0);
    end

    // R2: requester 3 raised outside its slot is ignored until slot 3
    @(negedge clk);
    while (slot_id != 3'd4) @(negedge clk);
    drive(3, 1'b1, 5, 3, 16'hE505);
    #1;
    for (int k = 0; k < 7; k++) begin
      chk(mem_en == 1'b0 && req_ready[3] == 1'b0, "R2 foreign slot ignored",
          int'({mem_en, req_ready[3]}), 0);
      @(negedge clk); #1;
    end
    chk(slot_id == 3'd3 && mem_en && mem_we && mem_bank == 4'd5 && mem_wdata == 16'hE505,
        "R9 write issued in own slot", int'(mem_wdata), 16'hE505);
    @(posedge clk); #1;
    req_valid[3] = 1'b0;
    run_vec(3, 1'b0, 5, 3, 16'hE505, 0); // R7 write landed, R6 readback

    // R4: reset frees a bank that was just accessed
    repeat (LAT + 2) @(negedge clk);
    run_vec(0, 1'b1, 6, 1, 16'h7777, 0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(slot_id == 3'd0, "R1 slot after second reset", int'(slot_id), 0);
    run_vec(1, 1'b0, 6, 1, 16'h7777, 0); // R4 bank 6 accepted right after reset

    repeat (LAT + 3) @(negedge clk);
    chk(due_q.size() == 0, "R6 all responses seen", due_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule